// File: doc/BRIEF.md
# Latched Interrupt Status Register

This block holds the 8-bit interrupt status word of a power-management controller. Six of its bits are sticky flags fed by on-chip monitors. A falling power-good signal sets one. Any change in the presence of the external clock sets another. The thermal warning, thermal shutdown and input over-voltage comparators each set one while their live level is high. A pulse from the current-measurement engine sets the last. One further bit is a read-only summary: it is high while a secondary regulator interrupt vector is nonzero. Bit 6 is reserved.

Host software reads the word and clears flags by writing ones. A write of 0 to a bit leaves it as it is. An interrupt line stays asserted while any bit is set. The thermal shutdown and over-voltage flags are tied to a protection interlock. When either one sets, every enabled regulator is switched off and the general-purpose outputs are forced low. While the shutdown flag stays set, further enable requests are refused.

The monitor inputs are asynchronous and each one passes through a two-flop synchroniser. The measurement pulse, the secondary vector and the host port are synchronous to `clk`.

Top module: `pmic_irq_status`

## Requirements
- R1: After a synchronous reset, `stat_o`, `irq_o`, `reg_en_o` and `gpo_force_low_o` are all 0.
- R2: Bit 6 of `stat_o` reads 0 at all times, including after a write of 1 to it.
- R3: A host write (`wr_en_i`=1) clears each latched bit (7, 4, 3, 2, 1, 0) whose `wr_data_i` bit is 1. A latched bit whose `wr_data_i` bit is 0 keeps its value. The result is visible one clock after the write.
- R4: Bit 7 sets only when `pgood_i` falls from 1 to 0, on the third rising edge after the change. A rise of `pgood_i` leaves it at 0.
- R5: Bit 4 sets on both a rise and a fall of `extclk_det_i`, on the third rising edge after the change.
- R6: Bit 5 equals the OR of `sec_irq_i` one clock earlier. Host writes have no effect on it.
- R7: Bit 3 (thermal shutdown) and bit 1 (over-voltage) set while `tshut_i` or `vin_ovp_i` respectively is high, on the third rising edge after the rise. In that same cycle `reg_en_o` becomes all zeros and `gpo_force_low_o` becomes 1.
- R8: A pulse on `reg_on_req_i[n]` sets `reg_en_o[n]` one clock later, and a pulse on `reg_off_req_i[n]` clears it. While bit 3 is set, on-requests are ignored.
- R9: Bit 2 (thermal warning) sets while `twarn_i` is high and re-sets after a clear for as long as the input stays high.
- R10: A one-cycle pulse on `meas_done_i` sets bit 0 one clock later.
- R11: If a set event and a write-1 clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R12: `irq_o` is 1 exactly when `stat_o` is nonzero.
- R13: `gpo_force_low_o` stays 1 while bit 3 or bit 1 is set, and falls in the same cycle that the last of them is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgood_i | input | 1 | Power-good level, 1 = good, asynchronous |
| extclk_det_i | input | 1 | External clock present, asynchronous |
| twarn_i | input | 1 | Live thermal-warning comparator, asynchronous |
| tshut_i | input | 1 | Live thermal-shutdown comparator, asynchronous |
| vin_ovp_i | input | 1 | Live input over-voltage comparator, asynchronous |
| meas_done_i | input | 1 | Current-measurement-ready pulse, synchronous |
| sec_irq_i | input | SEC_W | Secondary regulator interrupt vector |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write data, 1 = clear |
| reg_on_req_i | input | NREG | Regulator enable request pulses |
| reg_off_req_i | input | NREG | Regulator disable request pulses |
| stat_o | output | 8 | Status word read by the host |
| irq_o | output | 1 | Interrupt line |
| reg_en_o | output | NREG | Regulator enables |
| gpo_force_low_o | output | 1 | Forces the general-purpose outputs low |

## Verification
A flag that is stuck or set wrongly shows up at `stat_o` and `irq_o` on the edge after its cause. A missed clear or a wrongly held bit also leaves `irq_o` high. A bad synchroniser depth moves the set of a monitor flag off its third-edge slot, which the directed timing checks catch. A wrong interlock state shows as a regulator left enabled on the same edge the fault flag appears, or as an enable accepted while the shutdown flag is set. The sweep over all 256 write values, with every flag armed, exposes any wrong mask on clear or on the read-only and reserved bits within one clock.

// File: rtl/pmic_irq_pkg.sv
package pmic_irq_pkg;
  localparam int STAT_W = 8;
  localparam int NFLAG  = 6;
  localparam int NMON   = 5;
  // bit positions decoded by host software
  localparam int B_PG    = 7;
  localparam int B_RSVD  = 6;
  localparam int B_SUM   = 5;
  localparam int B_CLK   = 4;
  localparam int B_TSD   = 3;
  localparam int B_TWARN = 2;
  localparam int B_OVP   = 1;
  localparam int B_MEAS  = 0;
  // index of each monitor in the synchroniser vector
  localparam int M_PG    = 0;
  localparam int M_CLK   = 1;
  localparam int M_TWARN = 2;
  localparam int M_TSD   = 3;
  localparam int M_OVP   = 4;
  // index of each latched flag in the flag vector
  localparam int F_MEAS  = 0;
  localparam int F_OVP   = 1;
  localparam int F_TWARN = 2;
  localparam int F_TSD   = 3;
  localparam int F_CLK   = 4;
  localparam int F_PG    = 5;
endpackage

// File: rtl/pmic_irq_sync.sv
module pmic_irq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pmic_irq_flags.sv
module pmic_irq_flags #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  // a set event outranks a clear in the same cycle
  assign nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt_o;
  end

  for (genvar b = 0; b < W; b++) begin : g_chk
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> q_o[b]); // R11
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (q_o[b] && clr_i[b] && !set_i[b]) |=> !q_o[b]); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (q_o[b] && !clr_i[b]) |=> q_o[b]); // R3
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
      (!q_o[b] && !set_i[b]) |=> !q_o[b]); // R3
  end
endmodule

// File: rtl/pmic_irq_interlock.sv
module pmic_irq_interlock #(
  parameter int NREG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fault_evt_i,
  input  logic            tshut_flag_i,
  input  logic            force_cond_i,
  input  logic [NREG-1:0] on_req_i,
  input  logic [NREG-1:0] off_req_i,
  output logic [NREG-1:0] reg_en_o,
  output logic            force_low_o
);
  logic [NREG-1:0] en_nxt;

  always_comb begin
    if (fault_evt_i) en_nxt = '0;
    else en_nxt = (reg_en_o | (on_req_i & {NREG{~tshut_flag_i}})) & ~off_req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_en_o    <= '0;
      force_low_o <= 1'b0;
    end else begin
      reg_en_o    <= en_nxt;
      force_low_o <= force_cond_i;
    end
  end

  AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (rst)
    fault_evt_i |=> (reg_en_o == '0)); // R7
  AST_TSD_BLOCKS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    tshut_flag_i |=> ((reg_en_o & ~$past(reg_en_o)) == '0)); // R8
  AST_FAULT_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    fault_evt_i |=> force_low_o); // R7
endmodule

// File: rtl/pmic_irq_status.sv
module pmic_irq_status
  import pmic_irq_pkg::*;
#(
  parameter int SEC_W       = 8,
  parameter int NREG        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pgood_i,
  input  logic              extclk_det_i,
  input  logic              twarn_i,
  input  logic              tshut_i,
  input  logic              vin_ovp_i,
  input  logic              meas_done_i,
  input  logic [SEC_W-1:0]  sec_irq_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [NREG-1:0]   reg_on_req_i,
  input  logic [NREG-1:0]   reg_off_req_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o,
  output logic [NREG-1:0]   reg_en_o,
  output logic              gpo_force_low_o
);
  logic [NMON-1:0]  mon_raw, mon_s;
  logic             pg_prev_q, clk_prev_q;
  logic [NFLAG-1:0] set_evt, clr_req, flag_q, flag_nxt;
  logic             sum_q, irq_q;

  assign mon_raw[M_PG]    = pgood_i;
  assign mon_raw[M_CLK]   = extclk_det_i;
  assign mon_raw[M_TWARN] = twarn_i;
  assign mon_raw[M_TSD]   = tshut_i;
  assign mon_raw[M_OVP]   = vin_ovp_i;

  pmic_irq_sync #(.W(NMON), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (mon_raw),
    .q_o (mon_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_prev_q  <= 1'b0;
      clk_prev_q <= 1'b0;
    end else begin
      pg_prev_q  <= mon_s[M_PG];
      clk_prev_q <= mon_s[M_CLK];
    end
  end

  assign set_evt[F_PG]    = pg_prev_q & ~mon_s[M_PG];
  assign set_evt[F_CLK]   = clk_prev_q ^ mon_s[M_CLK];
  assign set_evt[F_TSD]   = mon_s[M_TSD];
  assign set_evt[F_TWARN] = mon_s[M_TWARN];
  assign set_evt[F_OVP]   = mon_s[M_OVP];
  assign set_evt[F_MEAS]  = meas_done_i;

  assign clr_req[F_PG]    = wr_en_i & wr_data_i[B_PG];
  assign clr_req[F_CLK]   = wr_en_i & wr_data_i[B_CLK];
  assign clr_req[F_TSD]   = wr_en_i & wr_data_i[B_TSD];
  assign clr_req[F_TWARN] = wr_en_i & wr_data_i[B_TWARN];
  assign clr_req[F_OVP]   = wr_en_i & wr_data_i[B_OVP];
  assign clr_req[F_MEAS]  = wr_en_i & wr_data_i[B_MEAS];

  pmic_irq_flags #(.W(NFLAG)) flags_i (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_evt),
    .clr_i (clr_req),
    .q_o   (flag_q),
    .nxt_o (flag_nxt)
  );

  pmic_irq_interlock #(.NREG(NREG)) lock_i (
    .clk          (clk),
    .rst          (rst),
    .fault_evt_i  (set_evt[F_TSD] | set_evt[F_OVP]),
    .tshut_flag_i (flag_q[F_TSD]),
    .force_cond_i (flag_nxt[F_TSD] | flag_nxt[F_OVP]),
    .on_req_i     (reg_on_req_i),
    .off_req_i    (reg_off_req_i),
    .reg_en_o     (reg_en_o),
    .force_low_o  (gpo_force_low_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= |sec_irq_i;
      irq_q <= (|flag_nxt) | (|sec_irq_i);
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[B_PG]    = flag_q[F_PG];
    stat_o[B_SUM]   = sum_q;
    stat_o[B_CLK]   = flag_q[F_CLK];
    stat_o[B_TSD]   = flag_q[F_TSD];
    stat_o[B_TWARN] = flag_q[F_TWARN];
    stat_o[B_OVP]   = flag_q[F_OVP];
    stat_o[B_MEAS]  = flag_q[F_MEAS];
  end
  assign irq_o = irq_q;

  AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_o == (stat_o != '0)); // R12
  AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (sec_irq_i == '0) |=> !stat_o[B_SUM]); // R6
  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stat_o[B_TSD] || stat_o[B_OVP]) |-> gpo_force_low_o); // R13
endmodule

// File: tb/pmic_irq_status_tb_top.sv
module pmic_irq_status_tb_top;
  localparam int SEC_W = 8;
  localparam int NREG  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pgood = 1'b0, extclk = 1'b0, twarn = 1'b0, tshut = 1'b0, ovp = 1'b0;
  logic meas = 1'b0;
  logic [SEC_W-1:0] sec = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [NREG-1:0] on_req = '0, off_req = '0;
  logic [7:0] stat;
  logic irq, force_low;
  logic [NREG-1:0] reg_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmic_irq_status #(.SEC_W(SEC_W), .NREG(NREG)) dut_i (
    .clk (clk), .rst (rst), .pgood_i (pgood), .extclk_det_i (extclk),
    .twarn_i (twarn), .tshut_i (tshut), .vin_ovp_i (ovp), .meas_done_i (meas),
    .sec_irq_i (sec), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .reg_on_req_i (on_req), .reg_off_req_i (off_req),
    .stat_o (stat), .irq_o (irq), .reg_en_o (reg_en), .gpo_force_low_o (force_low)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // raise all six latched flags with every live input back low
  task automatic arm_all();
    pgood = 1'b1; step(3);
    pgood = 1'b0; extclk = ~extclk;
    twarn = 1'b1; tshut = 1'b1; ovp = 1'b1; meas = 1'b1;
    step(1);
    meas = 1'b0; twarn = 1'b0; tshut = 1'b0; ovp = 1'b0;
    step(4);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 stat", stat, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 reg_en", reg_en, 0);
    chk("R1 force_low", force_low, 0);

    // R4 power-good rise gives no flag, fall sets on third edge
    pgood = 1'b1; step(3);
    chk("R4 rise ignored", stat[7], 0);
    pgood = 1'b0; step(2);
    chk("R4 not before third edge", stat[7], 0);
    step(1);
    chk("R4 fall sets", stat[7], 1);
    chk("R12 irq with bit7", irq, 1);
    host_wr(8'h80);
    chk("R3 clear bit7", stat, 8'h00);
    chk("R12 irq clears", irq, 0);

    // R5 both edges of clock presence
    extclk = 1'b1; step(3);
    chk("R5 appear sets", stat, 8'h10);
    host_wr(8'h10);
    extclk = 1'b0; step(3);
    chk("R5 disappear sets", stat, 8'h10);
    host_wr(8'h10);

    // R9 level warning re-sets while high; R11 clear loses
    twarn = 1'b1; step(3);
    chk("R9 warn sets", stat, 8'h04);
    host_wr(8'h04);
    chk("R9 R11 warn stays while high", stat[2], 1);
    twarn = 1'b0; step(3);
    host_wr(8'h04);
    chk("R9 warn clears when low", stat, 8'h00);

    // R10 measurement pulse; R11 with same-cycle clear
    meas = 1'b1; step(1); meas = 1'b0;
    chk("R10 meas sets", stat, 8'h01);
    meas = 1'b1; wr_en = 1'b1; wr_data = 8'h01; step(1);
    meas = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R11 event beats clear", stat, 8'h01);
    host_wr(8'h01);
    chk("R3 meas cleared", stat, 8'h00);

    // R2 reserved bit and R6 summary
    host_wr(8'h40);
    chk("R2 reserved zero", stat, 8'h00);
    sec = 8'h02; step(1);
    chk("R6 summary set", stat, 8'h20);
    chk("R12 irq from summary", irq, 1);
    host_wr(8'h20);
    chk("R6 write ignored", stat, 8'h20);
    sec = '0; step(1);
    chk("R6 summary clears", stat, 8'h00);

    // R8 enables, R7 thermal shutdown interlock
    on_req = 2'b11; step(1); on_req = '0;
    chk("R8 enable", reg_en, 2'b11);
    off_req = 2'b01; step(1); off_req = '0;
    chk("R8 disable one", reg_en, 2'b10);
    on_req = 2'b01; step(1); on_req = '0;
    tshut = 1'b1; step(2);
    chk("R7 not yet off", reg_en, 2'b11);
    step(1);
    chk("R7 tsd flag", stat, 8'h08);
    chk("R7 regulators off", reg_en, 2'b00);
    chk("R7 force low", force_low, 1);
    tshut = 1'b0; step(3);
    on_req = 2'b11; step(1); on_req = '0;
    chk("R8 enable blocked", reg_en, 2'b00);
    chk("R13 force held", force_low, 1);
    host_wr(8'h08);
    chk("R13 force released", force_low, 0);
    on_req = 2'b10; step(1); on_req = '0;
    chk("R8 enable after clear", reg_en, 2'b10);

    // R7 over-voltage: disables but does not block after clear of level
    ovp = 1'b1; step(3);
    chk("R7 ovp flag", stat, 8'h02);
    chk("R7 ovp off", reg_en, 2'b00);
    ovp = 1'b0; step(3);
    on_req = 2'b01; step(1); on_req = '0;
    chk("R8 ovp does not block", reg_en, 2'b01);
    chk("R13 ovp force held", force_low, 1);
    tshut = 1'b1; step(3); tshut = 1'b0; step(3);
    host_wr(8'h02);
    chk("R13 held by tsd", force_low, 1);
    host_wr(8'h08);
    chk("R13 both cleared", force_low, 0);

    // R3 R6 R12 sweep of every write value over all armed flags
    for (int v = 0; v < 256; v++) begin
      arm_all();
      sec = v[7:0];
      host_wr(v[7:0]);
      chk($sformatf("R3 sweep %0d", v), stat,
          (8'h9F & ~v[7:0]) | ((v != 0) ? 8'h20 : 8'h00));
      chk($sformatf("R12 sweep %0d", v), irq,
          (((8'h9F & ~v[7:0]) != 0) || (v != 0)) ? 1 : 0);
      sec = '0;
      host_wr(8'hFF);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule